// File: doc/BRIEF.md
# Fault Injection Countdown Timer

This block schedules deliberate error injections for reliability testing. Software programs a countdown value and a control word through a small word-addressed register port. A hidden working counter is loaded from the countdown value whenever the control word is written with its run bit set. While running, the counter steps down by one on every cycle where the rate strobe `tick_en` is high. The tick that brings the counter from one to zero fires a single-cycle `err_gen` pulse carrying the code of the chosen error type.

In one-shot mode the counter then rests at zero until software arms it again. In repeat mode the counter is reloaded from the countdown value as it expires, so injections recur every N ticks. The error type is taken from a set of per-type enable bits: the lowest-numbered enabled type wins, and with no type enabled no error is raised. The working counter never appears on the read port. Reads return only the programmed countdown value and the control word.

Top module: `fi_countdown_timer`

## Requirements
- R1: Word address 0 holds the countdown register. Bits [CNT_W-1:0] are read/write, and bits [REG_W-1:CNT_W] read as zero with writes to them ignored.
- R2: Word address 1 holds the control word. Bit 0 is run, bit 1 is repeat, and bits [2+NUM_TYPES-1:2] are the per-type enables. All other control bits read zero, and any other address reads zero and ignores writes.
- R3: A control write with bit 0 set copies the countdown value (as held before that write) into the working counter. This happens on every such write, even when run is already 1, and it takes priority over a tick in the same cycle.
- R4: While run is 1 and the working counter is nonzero, each cycle with `tick_en` high lowers the counter by exactly one. Cycles with `tick_en` low leave it unchanged.
- R5: The tick that takes the counter from 1 to 0 makes `err_gen` high for exactly the next cycle, provided at least one type is enabled.
- R6: `err_type` during a pulse is the index of the lowest-numbered enable bit set in that tick's cycle. With no enable set, no pulse is produced. `err_type` is 0 when `err_gen` is low.
- R7: With repeat at 0, an expired counter stays at zero, and no further pulses occur until run is written with 1 again.
- R8: With repeat at 1, expiry reloads the counter from the countdown value, giving one pulse every N ticks for a countdown value N.
- R9: A control write with bit 0 clear stops counting and holds the counter. A later run write reloads the counter and does not resume from the held value.
- R10: Loading a countdown value of zero never produces a pulse, in either mode.
- R11: After reset, `err_gen` is 0 and both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data for `addr`, combinational |
| tick_en | input | 1 | Countdown rate strobe, one cycle per step |
| err_gen | output | 1 | One-cycle error injection pulse |
| err_type | output | TYPE_W | Index of the injected error type |

## Verification
The counter is driven with back-to-back ticks and with ticks separated by idle cycles. This separates counting per tick from counting per clock. One-shot and repeat runs over more ticks than the countdown value show whether expiry rests or reloads. Stop-then-rearm sequences and a run write in the same cycle as a tick show whether a load reloads or resumes, and whether it wins over the tick. Enable sets with several bits, with only the top bit and with no bits, together with zero countdown values, exercise type priority and the cases where no pulse should appear.

// File: rtl/fi_cdn_pkg.sv
package fi_cdn_pkg;
   // register word indices
   localparam int CDN_IDX      = 0;
   localparam int CTL_IDX      = 1;
   // control word bit positions
   localparam int CTL_RUN      = 0;
   localparam int CTL_RPT      = 1;
   localparam int CTL_TYPE_LSB = 2;

   function automatic int type_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/fi_cdn_regs.sv
module fi_cdn_regs
   import fi_cdn_pkg::*;
#(
   parameter int REG_W     = 64,
   parameter int CNT_W     = 32,
   parameter int NUM_TYPES = 4,
   parameter int ADDR_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     rdata,
   output logic [CNT_W-1:0]     cdn_val,
   output logic                 run,
   output logic                 rpt,
   output logic [NUM_TYPES-1:0] types,
   output logic                 load
);
   localparam logic [ADDR_W-1:0] A_CDN = ADDR_W'(CDN_IDX);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_IDX);

   logic wr_cdn, wr_ctl;
   logic unused_wdata_hi;

   assign wr_cdn = wr_en && (addr == A_CDN);
   assign wr_ctl = wr_en && (addr == A_CTL);
   assign load   = wr_ctl && wdata[CTL_RUN];
   assign unused_wdata_hi = ^wdata[REG_W-1:CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cdn_val <= '0;
      end else if (wr_cdn) begin
         cdn_val <= wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         rpt   <= 1'b0;
         types <= '0;
      end else if (wr_ctl) begin
         run   <= wdata[CTL_RUN];
         rpt   <= wdata[CTL_RPT];
         types <= wdata[CTL_TYPE_LSB +: NUM_TYPES];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CDN) begin
         rdata[CNT_W-1:0] = cdn_val;
      end else if (addr == A_CTL) begin
         rdata[CTL_RUN]                   = run;
         rdata[CTL_RPT]                   = rpt;
         rdata[CTL_TYPE_LSB +: NUM_TYPES] = types;
      end
   end
endmodule

// File: rtl/fi_cdn_counter.sv
module fi_cdn_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   input  logic             rpt,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic step;

   assign step   = run && tick && !load && (cnt != '0);
   assign expire = step && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (expire) begin
         cnt <= rpt ? load_val : '0;
      end else if (step) begin
         cnt <= cnt - ONE;
      end
   end
endmodule

// File: rtl/fi_cdn_select.sv
module fi_cdn_select #(
   parameter int NUM_TYPES = 4,
   parameter int TYPE_W    = 2
) (
   input  logic [NUM_TYPES-1:0] types,
   output logic                 any,
   output logic [TYPE_W-1:0]    idx
);
   assign any = |types;

   generate
      if (NUM_TYPES == 1) begin : g_single
         assign idx = '0;
      end else begin : g_prio
         always_comb begin
            idx = '0;
            for (int i = NUM_TYPES - 1; i >= 0; i--) begin
               if (types[i]) idx = TYPE_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fi_countdown_timer.sv
module fi_countdown_timer
   import fi_cdn_pkg::*;
#(
   parameter int REG_W     = 64,
   parameter int CNT_W     = 32,
   parameter int NUM_TYPES = 4,
   parameter int ADDR_W    = 2,
   localparam int TYPE_W   = type_width(NUM_TYPES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic              tick_en,
   output logic              err_gen,
   output logic [TYPE_W-1:0] err_type
);
   generate
      if (CNT_W < 1 || CNT_W >= REG_W) begin : g_bad_cnt
         $error("CNT_W must lie in 1..REG_W-1");
      end
      if (NUM_TYPES < 1 || CTL_TYPE_LSB + NUM_TYPES > REG_W) begin : g_bad_types
         $error("NUM_TYPES does not fit the control word");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]     cdn_val;
   logic [CNT_W-1:0]     work_cnt;
   logic                 run, rpt, load, expire, any_type;
   logic [NUM_TYPES-1:0] types;
   logic [TYPE_W-1:0]    sel_idx;

   fi_cdn_regs #(
      .REG_W(REG_W), .CNT_W(CNT_W), .NUM_TYPES(NUM_TYPES), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .cdn_val(cdn_val), .run(run), .rpt(rpt),
      .types(types), .load(load)
   );

   fi_cdn_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(cdn_val),
      .run(run), .rpt(rpt), .tick(tick_en), .cnt(work_cnt), .expire(expire)
   );

   fi_cdn_select #(.NUM_TYPES(NUM_TYPES), .TYPE_W(TYPE_W)) u_sel (
      .types(types), .any(any_type), .idx(sel_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_gen  <= 1'b0;
         err_type <= '0;
      end else begin
         err_gen  <= expire && any_type;
         err_type <= (expire && any_type) ? sel_idx : '0;
      end
   end
endmodule

// File: rtl/fi_cdn_checker.sv
module fi_cdn_checker #(
   parameter int REG_W     = 64,
   parameter int CNT_W     = 32,
   parameter int NUM_TYPES = 4,
   parameter int ADDR_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick_en,
   input logic [ADDR_W-1:0]    addr,
   input logic [REG_W-1:0]     rdata,
   input logic                 run,
   input logic                 load,
   input logic [NUM_TYPES-1:0] types,
   input logic [CNT_W-1:0]     cdn_val,
   input logic [CNT_W-1:0]     cnt,
   input logic                 err_gen
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // R1: reserved upper half of the countdown word reads zero
   p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == '0) |-> (rdata[REG_W-1:CNT_W] == '0));

   // R3: run write loads the held countdown value
   p_load_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(cdn_val)));

   // R3: a load cycle never expires
   p_load_no_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !err_gen);

   // R4: one step per tick above one
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick_en && !load && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

   // R4: no change without a tick
   p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !load) |=> $stable(cnt));

   // R5: a pulse follows a running tick
   p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_gen |-> ($past(tick_en) && $past(run)));

   // R6: a pulse needs an enabled type
   p_pulse_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_gen |-> ($past(types) != '0));

   // R7: resting at zero stays at zero
   p_rest_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load) |=> (cnt == '0));

   // R9: stopped counter holds
   p_stopped_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt));

   // R10: zero counter raises nothing
   p_zero_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |=> !err_gen);
endmodule

bind fi_countdown_timer fi_cdn_checker #(
   .REG_W(REG_W), .CNT_W(CNT_W), .NUM_TYPES(NUM_TYPES), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .rdata(rdata),
   .run(run), .load(load), .types(types), .cdn_val(cdn_val),
   .cnt(work_cnt), .err_gen(err_gen)
);

// File: tb/fi_countdown_timer_bench.sv
module fi_countdown_timer_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  addr;
   logic [63:0] wdata;
   logic [63:0] rdata;
   logic        tick_en;
   logic        err_gen;
   logic [1:0]  err_type;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int last_type = -1;
   bit done = 0;

   // behavioural reference state
   logic [31:0] m_cdn, m_cnt;
   logic        m_run, m_rpt, m_gen, m_ld;
   logic [3:0]  m_types;
   logic [1:0]  m_type;

   fi_countdown_timer u_fi_countdown_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tick_en(tick_en), .err_gen(err_gen), .err_type(err_type)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_rd(input logic [1:0] a);
      if (a == 2'd0) return {32'h0, m_cdn};
      if (a == 2'd1) return {58'h0, m_types, m_rpt, m_run};
      return 64'h0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cdn = 0; m_cnt = 0; m_run = 0; m_rpt = 0; m_types = 0;
         m_gen = 0; m_type = 0;
      end else begin
         m_gen = 0; m_type = 0;
         m_ld = wr_en && addr == 2'd1 && wdata[0];
         if (m_ld) m_cnt = m_cdn;
         else if (m_run && tick_en && m_cnt != 0) begin
            if (m_cnt == 1) begin
               for (int i = 0; i < 4; i++)
                  if (m_types[i] && !m_gen) begin m_gen = 1; m_type = 2'(i); end
               m_cnt = m_rpt ? m_cdn : 32'h0;
            end else m_cnt = m_cnt - 1;
         end
         if (wr_en && addr == 2'd0) m_cdn = wdata[31:0];
         if (wr_en && addr == 2'd1) begin
            m_run = wdata[0]; m_rpt = wdata[1]; m_types = wdata[5:2];
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(err_gen == m_gen, "R5 err_gen", longint'(err_gen), longint'(m_gen));
         check(err_type == m_type, "R6 err_type", longint'(err_type), longint'(m_type));
         check(rdata == exp_rd(addr), (addr == 2'd0) ? "R1 rdata" : "R2 rdata",
               longint'(rdata), longint'(exp_rd(addr)));
         if (err_gen) begin pulses++; last_type = int'(err_type); end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [63:0] d, input bit t = 0);
      @(posedge clk); #1;
      wr_en = 1; addr = a; wdata = d; tick_en = t;
      @(posedge clk); #1;
      wr_en = 0; tick_en = 0; wdata = 0;
   endtask

   task automatic ticks(input int n, input int gap);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1; tick_en = 1;
         @(posedge clk); #1; tick_en = 0;
         repeat (gap) @(posedge clk);
      end
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic [1:0] a, input logic [63:0] exp, input string tag);
      @(posedge clk); #1; addr = a; #1;
      check(rdata == exp, tag, longint'(rdata), longint'(exp));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 0; wr_en = 0; addr = 0; wdata = 0; tick_en = 0;
      repeat (3) @(posedge clk);
      #1;
      check(err_gen == 0, "R11 err_gen", longint'(err_gen), 0);
      check(rdata == 0, "R11 cdn read", longint'(rdata), 0);
      addr = 1; #1;
      check(rdata == 0, "R11 ctl read", longint'(rdata), 0);
      addr = 0;
      @(posedge clk); #1; rst_n = 1;

      // R1: upper half dropped
      wr(0, 64'hDEAD_BEEF_0000_0005);
      rd(0, 64'h5, "R1 upper bits ignored");

      // one-shot, types 1 and 2 enabled, gapped ticks
      wr(1, 64'd25);
      pulses = 0;
      ticks(4, 1);
      check(pulses == 0, "R4 no pulse before N ticks", pulses, 0);
      ticks(1, 0);
      check(pulses == 1, "R5 pulse at expiry", pulses, 1);
      check(last_type == 1, "R6 lowest enabled type", last_type, 1);
      ticks(6, 0);
      check(pulses == 1, "R7 one-shot rests", pulses, 1);

      // repeat, only type 3
      wr(0, 64'd3);
      wr(1, 64'd35);
      pulses = 0;
      ticks(9, 0);
      check(pulses == 3, "R8 periodic pulses", pulses, 3);
      check(last_type == 3, "R6 top type alone", last_type, 3);

      // stop, hold, rearm reloads
      wr(1, 64'd0);
      wr(0, 64'd6);
      wr(1, 64'd5);
      pulses = 0;
      ticks(3, 0);
      wr(1, 64'd4);
      ticks(10, 0);
      check(pulses == 0, "R9 stopped holds", pulses, 0);
      wr(1, 64'd5);
      ticks(5, 0);
      check(pulses == 0, "R3 rearm reloads full value", pulses, 0);
      ticks(1, 0);
      check(pulses == 1, "R3 expiry after reload", pulses, 1);

      // no types enabled
      wr(0, 64'd2);
      wr(1, 64'd1);
      pulses = 0;
      ticks(4, 0);
      check(pulses == 0, "R6 no enabled type", pulses, 0);

      // zero countdown, one-shot then repeat
      wr(0, 64'd0);
      wr(1, 64'd5);
      ticks(5, 0);
      wr(1, 64'd7);
      ticks(5, 0);
      check(pulses == 0, "R10 zero load quiet", pulses, 0);

      // load wins over simultaneous tick
      wr(0, 64'd2);
      wr(1, 64'd5, 1);
      ticks(1, 0);
      check(pulses == 0, "R3 load beats tick", pulses, 0);
      ticks(1, 0);
      check(pulses == 1, "R3 expiry after two ticks", pulses, 1);

      // control masking and unused address
      wr(1, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(1, 64'h3F, "R2 control bits masked");
      wr(1, 64'd0);
      wr(2, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(2, 64'h0, "R2 unused address");
      rd(0, 64'h2, "R2 unused write harmless");

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule